// File: doc/BRIEF.md
# I2C Port Expander with Per-Pin Reset Holds

This block is an I2C target that gives a host eight general-purpose pins through four byte registers: a pin-level view, an output latch, a read-inversion mask and a direction mask. The bus lines are sampled with the system clock. The block detects start and stop conditions and shifts bytes in on rising SCL. It pulls SDA low to acknowledge, and it shifts read data out on falling SCL. Its 7-bit address is the fixed nibble 0100 followed by three strap pins.

After reset every pin is an input with its driver off. The external line then floats, so a pull-down on the board holds each attached device in reset. The host releases devices by clearing direction bits. A pin whose direction bit is 0 drives its output-latch bit, which resets to 1. A register pointer persists across transactions. With the parameter `KEEP_PTR` set, a write transaction that begins once a pointer has been selected treats its first byte as data for that register. This lets the host toggle reset holds with a two-byte transfer.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After reset the output latch and direction mask read 0xFF, the inversion mask reads 0x00, `pin_oe` is 0x00 and `pin_o` is 0xFF.
- R2: The block acknowledges (SDA low in the ninth clock) only an address byte whose upper seven bits equal {4'b0100, `strap`}. It then acknowledges every byte written to it. Other addresses get no acknowledge and change nothing.
- R3: The command byte selects a register with bits [1:0] only (0 pin view, 1 output latch, 2 inversion mask, 3 direction mask). Bits [7:2] are ignored.
- R4: `pin_oe[i]` is the inverse of direction bit i, and `pin_o` equals the output latch. Writing 0x00 to the direction mask enables all eight drivers. Writing 0xF0 enables pins 0 to 3 only.
- R5: Register 0 reads the two-flop synchronised `pin_i` XOR the inversion mask. Writes to register 0 are acknowledged and have no effect.
- R6: Read data is sent MSB first from the selected register. The same register is sent again while the controller acknowledges. After a controller not-acknowledge, the block releases SDA.
- R7: The pointer survives a stop. A read transaction with no command byte returns the register selected last.
- R8: With `KEEP_PTR`=0, the first byte of every write transaction is a command. With `KEEP_PTR`=1 and a pointer already chosen since reset, that first byte is written as data into the selected register.
- R9: A start condition received inside a byte abandons it without writing anything, and a stop releases SDA.
- R10: Further data bytes in one write transaction all go to the same register, so the last byte remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap | input | 3 | Low three address bits |
| pin_i | input | 8 | Sampled pin levels |
| pin_o | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin driver enables, high drives |

## Verification
Two instances share one modelled open-drain bus with distinct straps. A write that hits the wrong instance, or an address match that ignores the straps, therefore shows up as a second acknowledge or a stray register change. The bench aborts a byte half way with a repeated start. A design that did not abandon the byte would latch garbage into the output latch. Command bytes carry random upper bits, which catches a decoder that uses more than two bits. Single-byte write transactions are sent to both pointer variants: a design that mixed up command and data would move the pointer in one case or corrupt the direction mask in the other. The bench reads register 0 under mixed directions and inversion masks, which shows whether the design folds the driven values, the inversion and the external levels in the right way.

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander #(
  parameter logic [3:0] ADDR_HI  = 4'b0100,
  parameter bit         KEEP_PTR = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;
  st_t st;

  logic [2:0] scl_s, sda_s;
  logic [7:0] sh, tx, out_r, pol_r, cfg_r, pin_s1, pin_s2, sel;
  logic [3:0] cnt;
  logic [1:0] ptr;
  logic       ptr_ok, rw, first, mack;

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl & ~scl_s[2];
  wire scl_fall = ~scl & scl_s[2];
  wire start_c  = scl & scl_s[2] & ~sda & sda_s[2];
  wire stop_c   = scl & scl_s[2] & sda & ~sda_s[2];
  wire addr_hit = (sh[7:1] == {ADDR_HI, strap});
  wire is_cmd   = first & ~(KEEP_PTR & ptr_ok);

  always_comb
    case (ptr)
      2'd0:    sel = pin_s2 ^ pol_r;
      2'd1:    sel = out_r;
      2'd2:    sel = pol_r;
      default: sel = cfg_r;
    endcase

  assign sda_oe = (st == S_AACK) | (st == S_WACK) | ((st == S_RD) & ~tx[7]);
  assign pin_o  = out_r;
  assign pin_oe = ~cfg_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s  <= 3'b111;
      sda_s  <= 3'b111;
      pin_s1 <= 8'hFF;
      pin_s2 <= 8'hFF;
      st     <= S_IDLE;
      sh     <= '0;
      tx     <= 8'hFF;
      cnt    <= '0;
      out_r  <= 8'hFF;
      pol_r  <= 8'h00;
      cfg_r  <= 8'hFF;
      ptr    <= '0;
      ptr_ok <= 1'b0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
    end else begin
      scl_s  <= {scl_s[1:0], scl_i};
      sda_s  <= {sda_s[1:0], sda_i};
      pin_s1 <= pin_i;
      pin_s2 <= pin_s1;
      if (start_c) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  st <= S_AACK;
                  rw <= sh[0];
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                if (is_cmd) begin
                  ptr    <= sh[1:0];
                  ptr_ok <= 1'b1;
                end else begin
                  case (ptr)
                    2'd1:    out_r <= sh;
                    2'd2:    pol_r <= sh;
                    2'd3:    cfg_r <= sh;
                    default: ;
                  endcase
                end
                st <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt   <= '0;
            first <= 1'b1;
            if (rw) begin
              tx <= sel;
              st <= S_RD;
            end else begin
              st <= S_WR;
            end
          end
          S_WACK: if (scl_fall) begin
            cnt   <= '0;
            first <= 1'b0;
            st    <= S_WR;
          end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) st <= S_RACK;
              else tx <= {tx[6:0], 1'b1};
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda;
            else if (scl_fall) begin
              if (mack) begin
                tx  <= sel;
                cnt <= '0;
                st  <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_gpio_expander_chk.sv
module i2c_gpio_expander_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe,
  input logic       in_wack
);
  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == 8'h00 && pin_o == 8'hFF));

  a_r4_oe_moves_on_ack: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe) |-> in_wack);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |-> ##3 !sda_oe);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |-> ##3 !sda_oe);
endmodule

bind i2c_gpio_expander i2c_gpio_expander_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .pin_o(pin_o), .pin_oe(pin_oe), .in_wack(st == S_WACK)
);

// File: tb/sim_i2c_gpio_expander.sv
module sim_i2c_gpio_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int WATCHDOG = 190000;
  localparam logic [6:0] A0 = 7'h22;
  localparam logic [6:0] A1 = 7'h25;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] ext0 = 8'h00;
  logic oe0, oe1;
  logic [7:0] po0, pe0, po1, pe1;
  int n_chk = 0, n_bad = 0;

  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_cfg = 8'hFF;

  wire sda = sda_m & ~oe0 & ~oe1;
  wire [7:0] pi0 = (pe0 & po0) | (~pe0 & ext0);
  wire [7:0] pi1 = pe1 & po1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_gpio_expander #(.KEEP_PTR(1'b0)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda), .sda_oe(oe0),
    .strap(3'b010), .pin_i(pi0), .pin_o(po0), .pin_oe(pe0));
  i2c_gpio_expander #(.KEEP_PTR(1'b1)) u1 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda), .sda_oe(oe1),
    .strap(3'b101), .pin_i(pi1), .pin_o(po1), .pin_oe(pe1));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [1:0] p);
    case (p)
      2'd0:    return ((~m_cfg & m_out) | (m_cfg & ext0)) ^ m_pol;
      2'd1:    return m_out;
      2'd2:    return m_pol;
      default: return m_cfg;
    endcase
  endfunction

  task automatic model_wr(input logic [1:0] p, input logic [7:0] d);
    case (p)
      2'd1: m_out = d;
      2'd2: m_pol = d;
      2'd3: m_cfg = d;
      default: ;
    endcase
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask
  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = {b[6:0], sda}; qw(); scl_m = 1'b0; qw();
    end
    sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                    output logic [2:0] acks);
    i2c_start();
    send_byte({a, 1'b0}, acks[2]);
    send_byte(cmd, acks[1]);
    send_byte(d, acks[0]);
    i2c_stop();
  endtask
  task automatic wr1(input logic [6:0] a, input logic [7:0] b, output logic [1:0] acks);
    i2c_start();
    send_byte({a, 1'b0}, acks[1]);
    send_byte(b, acks[0]);
    i2c_stop();
  endtask
  task automatic rd_nocmd(input logic [6:0] a, output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, d);
    i2c_stop();
  endtask
  task automatic rd(input logic [6:0] a, input logic [7:0] cmd, output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte({a, 1'b0}, k);
    send_byte(cmd, k);
    i2c_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, d);
    i2c_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] a3;
    logic [1:0] a2;
    logic [7:0] d, d2;
    logic k;
    void'($urandom(32'd20240517));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    chk("R1 pin_oe after reset", pe0, 8'h00);
    chk("R1 pin_o after reset", po0, 8'hFF);
    rd(A0, 8'h01, d); chk("R1 output latch reset", d, 8'hFF);
    rd(A0, 8'h02, d); chk("R1 inversion reset", d, 8'h00);
    rd(A0, 8'h03, d); chk("R1 direction reset", d, 8'hFF);

    wr(7'h27, 8'h03, 8'h00, a3);
    chk("R2 foreign address no ack", {5'd0, a3}, 8'h00);
    chk("R2 foreign address no effect", pe0, 8'h00);
    wr(A0, 8'hFD, 8'hA5, a3); model_wr(2'd1, 8'hA5);
    chk("R2 acks on own address", {5'd0, a3}, 8'h07);
    rd(A0, 8'h01, d); chk("R3 upper command bits ignored", d, 8'hA5);
    chk("R4 pin_o follows latch", po0, 8'hA5);

    wr(A0, 8'h03, 8'h00, a3); model_wr(2'd3, 8'h00);
    chk("R4 cfg 00 all drive", pe0, 8'hFF);
    wr(A0, 8'h03, 8'hF0, a3); model_wr(2'd3, 8'hF0);
    chk("R4 cfg F0 low nibble drive", pe0, 8'h0F);

    wr(A0, 8'h03, 8'hFF, a3); model_wr(2'd3, 8'hFF);
    wr(A0, 8'h02, 8'hF0, a3); model_wr(2'd2, 8'hF0);
    ext0 = 8'h3C;
    rd(A0, 8'h00, d); chk("R5 pin view xor inversion", d, 8'hCC);
    wr(A0, 8'h00, 8'h55, a3);
    chk("R5 write to pin view acked", {5'd0, a3}, 8'h07);
    rd(A0, 8'h00, d); chk("R5 write to pin view ignored", d, 8'hCC);
    wr(A0, 8'h03, 8'h0F, a3); model_wr(2'd3, 8'h0F);
    rd(A0, 8'h00, d); chk("R5 mixed directions", d, exp_reg(2'd0));

    wr(A0, 8'h01, 8'h96, a3); model_wr(2'd1, 8'h96);
    i2c_start();
    send_byte({A0, 1'b1}, k);
    recv_byte(1'b1, d);  chk("R6 first read byte", d, 8'h96);
    recv_byte(1'b0, d2); chk("R6 repeated read byte", d2, 8'h96);
    qw();
    chk("R6 released after nack", {7'd0, sda}, 8'h01);
    i2c_stop();

    wr(A0, 8'h02, 8'h33, a3); model_wr(2'd2, 8'h33);
    rd_nocmd(A0, d); chk("R7 pointer kept after stop", d, 8'h33);

    wr(A1, 8'h03, 8'h5A, a3);
    chk("R8 keep-ptr first write", pe1, 8'hA5);
    wr1(A1, 8'h0F, a2);
    chk("R8 keep-ptr byte taken as data", pe1, 8'hF0);
    wr1(A0, 8'h01, a2);
    chk("R8 default byte taken as command", pe0, ~m_cfg);
    rd_nocmd(A0, d); chk("R8 default pointer moved", d, m_out);

    i2c_start();
    send_byte({A0, 1'b0}, k);
    send_byte(8'h01, k);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start();
    send_byte({A0, 1'b1}, k);
    recv_byte(1'b0, d);
    i2c_stop();
    chk("R9 aborted byte not written", d, m_out);
    chk("R9 bus released", {7'd0, sda}, 8'h01);

    i2c_start();
    send_byte({A0, 1'b0}, k);
    send_byte(8'h01, k);
    send_byte(8'h11, k);
    send_byte(8'h22, k);
    send_byte(8'h3B, k);
    i2c_stop();
    model_wr(2'd1, 8'h3B);
    chk("R10 last data byte kept", po0, 8'h3B);

    for (int it = 0; it < 30; it++) begin
      logic [1:0] p;
      logic [7:0] v;
      p = 2'($urandom % 4);
      v = 8'($urandom);
      ext0 = 8'($urandom);
      wr(A0, {6'($urandom), p}, v, a3);
      model_wr(p, v);
      chk("R2 random acks", {5'd0, a3}, 8'h07);
      p = 2'($urandom % 4);
      rd(A0, {6'($urandom), p}, d);
      chk("R3 random read", d, exp_reg(p));
      chk("R4 random pin_oe", pe0, ~m_cfg);
      chk("R4 random pin_o", po0, m_out);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule